// File: doc/BRIEF.md
# Low Pin Count Bus Cycle Monitor

A passive observer for a four-bit multiplexed host bus. It samples the frame strobe (active low) and the four data lines on every bus clock and rebuilds each host cycle as it passes. The block never drives the bus. It follows the frame strobe into the start nibble, reads the cycle-type nibble, and collects a 16-bit or 32-bit address. It then walks the phases whose order depends on direction: turnaround, handshake (SYNC) and data. At the end of a cycle, or when a cycle is cut short, it raises a record valid for one clock. The record carries the start code, cycle kind, address, data byte, last SYNC nibble and a set of protocol error flags.

The block covers I/O and memory reads and writes. Any other cycle-type encoding produces a record at once, with a bad-type flag set. A static input chooses whether the bus is sampled on the rising or the falling clock edge. A second static input bounds how many wait handshakes a cycle may spend before the monitor gives up. The block sits next to a bus in a debug or trace path and feeds its records to a logger.

Top module: `lpc_cycle_monitor`

## Requirements
- R1: While `rst` is high on a rising edge, and on the clock after it, `rec_valid` is 0, every record field is 0 and the monitor waits for a new cycle.
- R2: A cycle opens when `bus_frame_n` is sampled low. Each further low sample replaces the start code, and the code reported is the nibble from the last low sample. If the nibble differs between two consecutive low samples, `rec_unstable` is set in that cycle's record.
- R3: The first sample with `bus_frame_n` high after the start gives the type nibble. Bit 3 must be 0, bit 2 selects memory (1) or I/O (0) and bit 1 selects write (1) or read (0). `rec_kind` reports {bit 2, bit 1}. A type nibble with bit 3 set ends the cycle with a record in which `rec_bad_type` is set and address, data and SYNC are zero.
- R4: I/O cycles take 4 address nibbles and memory cycles take 8, most significant nibble first. For an I/O cycle `rec_addr[31:16]` is 0.
- R5: A write runs address, 2 data nibbles (low nibble first), 2 turnaround clocks, SYNC and 2 turnaround clocks. The record appears on the clock after the last turnaround sample.
- R6: A read runs address, 2 turnaround clocks, SYNC, 2 data nibbles (low nibble first) and 2 turnaround clocks. The record appears on the clock after the last turnaround sample.
- R7: Every turnaround sample must read 1111. Any other value sets `rec_tar_err`, and the cycle carries on with unchanged timing.
- R8: SYNC nibbles 0101 and 0110 are waits that keep the monitor in the SYNC phase. Any other SYNC nibble ends the phase and is reported in `rec_sync`. Nibbles other than 0000, 0101, 0110, 1001 and 1010 set `rec_bad_sync`.
- R9: When the count of consecutive wait nibbles in one SYNC phase reaches `wait_limit` (1 or more), the cycle ends with a record on the next clock. That record has `rec_timeout` set and `rec_sync` holding the wait code.
- R10: A low frame sample in any phase after the type nibble ends the current cycle with a record that has `rec_abort` set. The same sample becomes the start nibble of a new cycle.
- R11: With `sample_fall` at 1, the bus is taken on the falling edge before each rising edge. Values present only around the rising edge are ignored.
- R12: `rec_valid` is high for exactly one clock per record, and all record fields hold their values until the next record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_fall | input | 1 | 1: sample on falling edge, 0: rising edge |
| wait_limit | input | WAIT_W | Wait-nibble count that triggers a timeout |
| bus_frame_n | input | 1 | Frame strobe, active low |
| bus_nib | input | 4 | Multiplexed bus nibble |
| rec_valid | output | 1 | One-clock record strobe |
| rec_start | output | 4 | Start code |
| rec_kind | output | 2 | {memory, write} |
| rec_addr | output | 32 | Address |
| rec_data | output | 8 | Data byte |
| rec_sync | output | 4 | Last SYNC nibble |
| rec_unstable | output | 1 | Start nibble changed while frame low |
| rec_bad_type | output | 1 | Unsupported type nibble |
| rec_tar_err | output | 1 | Turnaround sample was not 1111 |
| rec_bad_sync | output | 1 | Reserved SYNC nibble seen |
| rec_abort | output | 1 | Cycle cut short by a new frame |
| rec_timeout | output | 1 | Wait limit reached |

## Verification
The assertions check on every clock that:
- the record is cleared by reset;
- only one cause flag (abort, timeout, bad type) is set on a record;
- I/O addresses stay within 16 bits;
- a timeout reports a wait code and a normal end does not;
- fields hold between records;
- a low frame in a data-bearing phase yields an abort record on the next clock.

Only the bench scenarios show the rest, against a behavioural model:
- nibble ordering (address high nibble first, data low nibble first);
- the direction-dependent phase order and exact record timing;
- start-code replacement and the unstable flag;
- the reserved-SYNC and turnaround flags;
- the timeout count;
- that falling-edge sampling ignores values that are valid only around the rising edge.

// File: rtl/lpcmon_pkg.sv
package lpcmon_pkg;

  localparam int NIB_W  = 4;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 8;

  localparam logic [NIB_W-1:0] TAR_OK     = 4'hF;
  localparam logic [NIB_W-1:0] SY_READY   = 4'h0;
  localparam logic [NIB_W-1:0] SY_SHORT   = 4'h5;
  localparam logic [NIB_W-1:0] SY_LONG    = 4'h6;
  localparam logic [NIB_W-1:0] SY_MORE    = 4'h9;
  localparam logic [NIB_W-1:0] SY_ERROR   = 4'hA;

  typedef enum logic [2:0] {
    PH_IDLE, PH_START, PH_ADDR, PH_WDATA, PH_TAR1, PH_SYNC, PH_RDATA, PH_TAR2
  } phase_t;

  typedef struct packed {
    logic [NIB_W-1:0]  start;
    logic [1:0]        kind;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [NIB_W-1:0]  sync;
    logic              unstable;
    logic              bad_type;
    logic              tar_err;
    logic              bad_sync;
    logic              abort;
    logic              timeout;
  } rec_t;

  typedef struct packed {
    logic begin_start;
    logic track_start;
    logic cap_type;
    logic shift_addr;
    logic cap_dlo;
    logic cap_dhi;
    logic chk_tar;
    logic cap_sync;
    logic emit;
    logic why_abort;
    logic why_timeout;
    logic why_badtype;
  } ctl_t;

  function automatic logic sync_is_wait(input logic [NIB_W-1:0] n);
    return (n == SY_SHORT) || (n == SY_LONG);
  endfunction

  function automatic logic sync_is_known(input logic [NIB_W-1:0] n);
    return (n == SY_READY) || (n == SY_SHORT) || (n == SY_LONG) ||
           (n == SY_MORE)  || (n == SY_ERROR);
  endfunction

endpackage

// File: rtl/lpcmon_edge.sv
module lpcmon_edge
  import lpcmon_pkg::*;
(
  input  logic             clk,
  input  logic             sample_fall,
  input  logic             frame_n,
  input  logic [NIB_W-1:0] nib,
  output logic             s_frame,
  output logic [NIB_W-1:0] s_nib
);

  logic             fall_frame;
  logic [NIB_W-1:0] fall_nib;

  // Capture on the falling edge; the phase logic consumes it on the next rising edge.
  always_ff @(negedge clk) begin
    fall_frame <= frame_n;
    fall_nib   <= nib;
  end

  always_comb begin
    if (sample_fall) begin
      s_frame = fall_frame;
      s_nib   = fall_nib;
    end else begin
      s_frame = frame_n;
      s_nib   = nib;
    end
  end

endmodule

// File: rtl/lpcmon_seq.sv
module lpcmon_seq
  import lpcmon_pkg::*;
#(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_frame,
  input  logic [NIB_W-1:0]  s_nib,
  input  logic [WAIT_W-1:0] wait_limit,
  output ctl_t              ctl,
  output phase_t            phase
);

  localparam int CNT_W = 3;
  localparam logic [CNT_W-1:0] IO_LAST  = CNT_W'(ADDR_W / (2 * NIB_W) - 1);
  localparam logic [CNT_W-1:0] MEM_LAST = CNT_W'(ADDR_W / NIB_W - 1);

  phase_t            phase_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [1:0]        kind, kind_n;
  logic [WAIT_W-1:0] wcnt, wcnt_n;
  logic [WAIT_W:0]   wsum;
  logic [CNT_W-1:0]  addr_last;

  assign wsum      = {1'b0, wcnt} + (WAIT_W+1)'(1);
  assign addr_last = kind[1] ? MEM_LAST : IO_LAST;

  always_comb begin
    ctl     = '0;
    phase_n = phase;
    cnt_n   = cnt;
    kind_n  = kind;
    wcnt_n  = wcnt;
    case (phase)
      PH_IDLE: begin
        if (!s_frame) begin
          ctl.begin_start = 1'b1;
          phase_n         = PH_START;
        end
      end
      PH_START: begin
        if (!s_frame) begin
          ctl.track_start = 1'b1;
        end else begin
          ctl.cap_type = 1'b1;
          if (s_nib[3]) begin
            ctl.emit        = 1'b1;
            ctl.why_badtype = 1'b1;
            phase_n         = PH_IDLE;
          end else begin
            kind_n  = s_nib[2:1];
            cnt_n   = '0;
            phase_n = PH_ADDR;
          end
        end
      end
      default: begin
        if (!s_frame) begin
          ctl.emit        = 1'b1;
          ctl.why_abort   = 1'b1;
          ctl.begin_start = 1'b1;
          phase_n         = PH_START;
        end else begin
          case (phase)
            PH_ADDR: begin
              ctl.shift_addr = 1'b1;
              if (cnt == addr_last) begin
                cnt_n   = '0;
                phase_n = kind[0] ? PH_WDATA : PH_TAR1;
              end else begin
                cnt_n = cnt + 1'b1;
              end
            end
            PH_WDATA, PH_RDATA: begin
              if (cnt == '0) begin
                ctl.cap_dlo = 1'b1;
                cnt_n       = CNT_W'(1);
              end else begin
                ctl.cap_dhi = 1'b1;
                cnt_n       = '0;
                phase_n     = (phase == PH_WDATA) ? PH_TAR1 : PH_TAR2;
              end
            end
            PH_TAR1: begin
              ctl.chk_tar = 1'b1;
              if (cnt == '0) begin
                cnt_n = CNT_W'(1);
              end else begin
                cnt_n   = '0;
                wcnt_n  = '0;
                phase_n = PH_SYNC;
              end
            end
            PH_SYNC: begin
              ctl.cap_sync = 1'b1;
              if (sync_is_wait(s_nib)) begin
                if (wsum >= {1'b0, wait_limit}) begin
                  ctl.emit        = 1'b1;
                  ctl.why_timeout = 1'b1;
                  phase_n         = PH_IDLE;
                end else begin
                  wcnt_n = wsum[WAIT_W-1:0];
                end
              end else begin
                cnt_n   = '0;
                phase_n = kind[0] ? PH_TAR2 : PH_RDATA;
              end
            end
            PH_TAR2: begin
              ctl.chk_tar = 1'b1;
              if (cnt == '0) begin
                cnt_n = CNT_W'(1);
              end else begin
                cnt_n    = '0;
                ctl.emit = 1'b1;
                phase_n  = PH_IDLE;
              end
            end
            default: phase_n = PH_IDLE;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      kind  <= '0;
      wcnt  <= '0;
    end else begin
      phase <= phase_n;
      cnt   <= cnt_n;
      kind  <= kind_n;
      wcnt  <= wcnt_n;
    end
  end

endmodule

// File: rtl/lpcmon_rec.sv
module lpcmon_rec
  import lpcmon_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NIB_W-1:0] s_nib,
  input  ctl_t             ctl,
  output rec_t             rec,
  output logic             rec_valid
);

  rec_t work, nxt, fresh;

  always_comb begin
    fresh       = '0;
    fresh.start = s_nib;
  end

  always_comb begin
    nxt = work;
    if (ctl.track_start) begin
      if (s_nib != work.start) nxt.unstable = 1'b1;
      nxt.start = s_nib;
    end
    if (ctl.cap_type) begin
      nxt.kind = s_nib[2:1];
      if (ctl.why_badtype) nxt.bad_type = 1'b1;
    end
    if (ctl.shift_addr) nxt.addr = {work.addr[ADDR_W-NIB_W-1:0], s_nib};
    if (ctl.cap_dlo)    nxt.data[NIB_W-1:0] = s_nib;
    if (ctl.cap_dhi)    nxt.data[DATA_W-1:NIB_W] = s_nib;
    if (ctl.chk_tar && (s_nib != TAR_OK)) nxt.tar_err = 1'b1;
    if (ctl.cap_sync) begin
      nxt.sync = s_nib;
      if (!sync_is_known(s_nib)) nxt.bad_sync = 1'b1;
    end
    nxt.abort   = ctl.why_abort;
    nxt.timeout = ctl.why_timeout;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      work      <= '0;
      rec       <= '0;
      rec_valid <= 1'b0;
    end else begin
      work      <= ctl.begin_start ? fresh : nxt;
      rec_valid <= ctl.emit;
      if (ctl.emit) rec <= nxt;
    end
  end

endmodule

// File: rtl/lpc_cycle_monitor.sv
module lpc_cycle_monitor
  import lpcmon_pkg::*;
#(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_fall,
  input  logic [WAIT_W-1:0] wait_limit,
  input  logic              bus_frame_n,
  input  logic [3:0]        bus_nib,
  output logic              rec_valid,
  output logic [3:0]        rec_start,
  output logic [1:0]        rec_kind,
  output logic [31:0]       rec_addr,
  output logic [7:0]        rec_data,
  output logic [3:0]        rec_sync,
  output logic              rec_unstable,
  output logic              rec_bad_type,
  output logic              rec_tar_err,
  output logic              rec_bad_sync,
  output logic              rec_abort,
  output logic              rec_timeout
);

  logic             s_frame;
  logic [NIB_W-1:0] s_nib;
  ctl_t             ctl;
  phase_t           cur_phase;
  rec_t             rec;

  lpcmon_edge u_edge (
    .clk         (clk),
    .sample_fall (sample_fall),
    .frame_n     (bus_frame_n),
    .nib         (bus_nib),
    .s_frame     (s_frame),
    .s_nib       (s_nib)
  );

  lpcmon_seq #(.WAIT_W(WAIT_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .s_frame    (s_frame),
    .s_nib      (s_nib),
    .wait_limit (wait_limit),
    .ctl        (ctl),
    .phase      (cur_phase)
  );

  lpcmon_rec u_rec (
    .clk       (clk),
    .rst       (rst),
    .s_nib     (s_nib),
    .ctl       (ctl),
    .rec       (rec),
    .rec_valid (rec_valid)
  );

  assign rec_start    = rec.start;
  assign rec_kind     = rec.kind;
  assign rec_addr     = rec.addr;
  assign rec_data     = rec.data;
  assign rec_sync     = rec.sync;
  assign rec_unstable = rec.unstable;
  assign rec_bad_type = rec.bad_type;
  assign rec_tar_err  = rec.tar_err;
  assign rec_bad_sync = rec.bad_sync;
  assign rec_abort    = rec.abort;
  assign rec_timeout  = rec.timeout;

endmodule

// File: rtl/lpcmon_chk.sv
module lpcmon_chk
  import lpcmon_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        s_frame,
  input phase_t      cur_phase,
  input logic        rec_valid,
  input logic [1:0]  rec_kind,
  input logic [31:0] rec_addr,
  input logic [7:0]  rec_data,
  input logic [3:0]  rec_sync,
  input logic        rec_bad_type,
  input logic        rec_abort,
  input logic        rec_timeout
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!rec_valid && rec_addr == '0));

  // R3
  bad_type_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && rec_bad_type) |-> (rec_addr == '0 && rec_data == '0 && rec_sync == '0));

  // R4
  io_addr_width_chk: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && !rec_kind[1]) |-> (rec_addr[31:16] == '0));

  // R8
  normal_end_sync_chk: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && !rec_abort && !rec_timeout && !rec_bad_type) |-> !sync_is_wait(rec_sync));

  // R9
  timeout_wait_code_chk: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && rec_timeout) |-> sync_is_wait(rec_sync));

  // R10
  abort_record_chk: assert property (@(posedge clk) disable iff (rst)
    (!s_frame && cur_phase != PH_IDLE && cur_phase != PH_START) |=> (rec_valid && rec_abort));

  // R12
  one_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> ($countones({rec_abort, rec_timeout, rec_bad_type}) <= 1));

  // R12
  fields_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rec_valid |-> ($stable(rec_addr) && $stable(rec_data) && $stable(rec_sync)));

endmodule

bind lpc_cycle_monitor lpcmon_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .s_frame      (s_frame),
  .cur_phase    (cur_phase),
  .rec_valid    (rec_valid),
  .rec_kind     (rec_kind),
  .rec_addr     (rec_addr),
  .rec_data     (rec_data),
  .rec_sync     (rec_sync),
  .rec_bad_type (rec_bad_type),
  .rec_abort    (rec_abort),
  .rec_timeout  (rec_timeout)
);

// File: tb/lpc_cycle_monitor_tb.sv
`timescale 1ns/1ps
module lpc_cycle_monitor_tb;

  localparam int WAIT_W = 8;
  localparam int LIMIT  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample_fall = 1'b0;
  logic [WAIT_W-1:0] wait_limit = WAIT_W'(LIMIT);
  logic tb_frame = 1'b1;
  logic [3:0] tb_nib = 4'hF;

  logic rec_valid, rec_unstable, rec_bad_type, rec_tar_err, rec_bad_sync, rec_abort, rec_timeout;
  logic [3:0] rec_start, rec_sync;
  logic [1:0] rec_kind;
  logic [31:0] rec_addr;
  logic [7:0] rec_data;

  always #2.5 clk = ~clk;

  lpc_cycle_monitor #(.WAIT_W(WAIT_W)) u_dut (
    .clk(clk), .rst(rst), .sample_fall(sample_fall), .wait_limit(wait_limit),
    .bus_frame_n(tb_frame), .bus_nib(tb_nib),
    .rec_valid(rec_valid), .rec_start(rec_start), .rec_kind(rec_kind),
    .rec_addr(rec_addr), .rec_data(rec_data), .rec_sync(rec_sync),
    .rec_unstable(rec_unstable), .rec_bad_type(rec_bad_type), .rec_tar_err(rec_tar_err),
    .rec_bad_sync(rec_bad_sync), .rec_abort(rec_abort), .rec_timeout(rec_timeout)
  );

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";
  bit fall_mode = 1'b0;

  // Behavioural reference state
  int m_ph = 0;          // 0 idle,1 start,2 addr,3 wdata,4 tar1,5 sync,6 rdata,7 tar2
  int m_cnt = 0;
  int m_wait = 0;
  logic [3:0] w_start = 0, w_sync = 0;
  logic [1:0] w_kind = 0;
  logic [7:0] w_data = 0;
  logic [3:0] addr_q[$];
  bit w_uns = 0, w_bad = 0, w_tar = 0, w_bsync = 0;
  bit e_valid = 0;
  logic [55:0] e_vec = '0;

  task automatic m_fresh(input logic [3:0] n);
    w_start = n; w_sync = 0; w_kind = 0; w_data = 0; addr_q.delete();
    w_uns = 0; w_bad = 0; w_tar = 0; w_bsync = 0;
  endtask

  task automatic m_emit(input bit ab, input bit to);
    logic [31:0] a = '0;
    foreach (addr_q[i]) a = (a << 4) | 32'(addr_q[i]);
    e_valid = 1;
    e_vec = {w_start, w_kind, a, w_data, w_sync, w_uns, w_bad, w_tar, w_bsync, ab, to};
  endtask

  function automatic bit known_sync(input logic [3:0] n);
    return n == 4'h0 || n == 4'h5 || n == 4'h6 || n == 4'h9 || n == 4'hA;
  endfunction

  task automatic m_step(input bit f, input logic [3:0] n);
    e_valid = 0;
    if (m_ph == 0) begin
      if (!f) begin m_fresh(n); m_ph = 1; end
    end else if (m_ph == 1) begin
      if (!f) begin
        if (n != w_start) w_uns = 1;
        w_start = n;
      end else begin
        w_kind = n[2:1];
        if (n[3]) begin w_bad = 1; m_emit(0, 0); m_ph = 0; end
        else m_ph = 2;
      end
    end else if (!f) begin
      m_emit(1, 0); m_fresh(n); m_ph = 1;
    end else begin
      case (m_ph)
        2: begin
          addr_q.push_back(n);
          if (addr_q.size() == (w_kind[1] ? 8 : 4)) begin
            m_ph = w_kind[0] ? 3 : 4; m_cnt = 0;
          end
        end
        3, 6: begin
          if (m_cnt == 0) begin w_data[3:0] = n; m_cnt = 1; end
          else begin w_data[7:4] = n; m_cnt = 0; m_ph = (m_ph == 3) ? 4 : 7; end
        end
        4: begin
          if (n != 4'hF) w_tar = 1;
          if (m_cnt == 0) m_cnt = 1;
          else begin m_cnt = 0; m_wait = 0; m_ph = 5; end
        end
        5: begin
          w_sync = n;
          if (!known_sync(n)) w_bsync = 1;
          if (n == 4'h5 || n == 4'h6) begin
            m_wait++;
            if (m_wait >= LIMIT) begin m_emit(0, 1); m_ph = 0; end
          end else m_ph = w_kind[0] ? 7 : 6;
        end
        7: begin
          if (n != 4'hF) w_tar = 1;
          if (m_cnt == 0) m_cnt = 1;
          else begin m_cnt = 0; m_emit(0, 0); m_ph = 0; end
        end
        default: m_ph = 0;
      endcase
    end
  endtask

  task automatic compare();
    logic [55:0] act;
    act = {rec_start, rec_kind, rec_addr, rec_data, rec_sync, rec_unstable, rec_bad_type,
           rec_tar_err, rec_bad_sync, rec_abort, rec_timeout};
    checks++;
    // R12: record fields are compared every clock, so held values are checked too
    if (rec_valid !== e_valid || act !== e_vec) begin
      fails++;
      $display("FAIL %s: valid=%0b rec=%h expected valid=%0b rec=%h",
               cur_req, rec_valid, act, e_valid, e_vec);
    end
  endtask

  task automatic step(input bit f, input logic [3:0] n);
    @(posedge clk); #1;
    if (fall_mode) begin tb_frame = f; tb_nib = n; end
    @(negedge clk); #1;
    compare();
    if (fall_mode) tb_nib = n ^ 4'h5;   // R11: value only present around the rising edge
    else begin tb_frame = f; tb_nib = n; end
    m_step(f, n);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) step(1, 4'hF);
  endtask

  task automatic run_cycle(input logic [3:0] st, input int hold, input logic [3:0] ct,
                           input logic [31:0] a, input logic [7:0] d, input int waits,
                           input logic [3:0] wcode, input logic [3:0] fin,
                           input logic [3:0] tarv);
    int na;
    na = ct[2] ? 8 : 4;
    for (int i = 0; i < hold; i++) step(0, st);
    step(1, ct);
    for (int i = na - 1; i >= 0; i--) step(1, a[i*4 +: 4]);
    if (ct[1]) begin step(1, d[3:0]); step(1, d[7:4]); end
    step(1, 4'hF); step(1, tarv);
    for (int i = 0; i < waits; i++) step(1, wcode);
    step(1, fin);
    if (!ct[1]) begin step(1, d[3:0]); step(1, d[7:4]); end
    step(1, 4'hF); step(1, 4'hF);
    idle(2);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    cur_req = "R1"; idle(3);                                            // R1 reset state
    cur_req = "R5"; run_cycle(4'h0, 1, 4'h2, 32'h1234, 8'hA5, 0, 4'h5, 4'h0, 4'hF);
    cur_req = "R6"; run_cycle(4'h0, 1, 4'h4, 32'hDEADBEEF, 8'h3C, 2, 4'h5, 4'h0, 4'hF);
    cur_req = "R4"; run_cycle(4'h0, 1, 4'h0, 32'h0000BEEF, 8'h81, 0, 4'h5, 4'h9, 4'hF);
    cur_req = "R4"; run_cycle(4'h0, 1, 4'h6, 32'h89ABCDEF, 8'h42, 1, 4'h6, 4'hA, 4'hF);
    cur_req = "R2"; step(0, 4'h3); step(0, 4'h3);
    run_cycle(4'h0, 2, 4'h0, 32'h0055, 8'h11, 0, 4'h5, 4'h0, 4'hF);
    cur_req = "R2"; run_cycle(4'h7, 3, 4'h2, 32'h00AA, 8'h22, 0, 4'h5, 4'h0, 4'hF);
    cur_req = "R3"; step(0, 4'h0); step(1, 4'h8); idle(2);
    cur_req = "R3"; step(0, 4'h0); step(1, 4'hE); idle(2);
    cur_req = "R7"; run_cycle(4'h0, 1, 4'h2, 32'h0100, 8'h5A, 0, 4'h5, 4'h0, 4'h7);
    cur_req = "R8"; run_cycle(4'h0, 1, 4'h0, 32'h0200, 8'h77, 3, 4'h6, 4'h3, 4'hF);
    cur_req = "R9"; run_cycle(4'h0, 1, 4'h4, 32'h00001000, 8'h99, 6, 4'h5, 4'h0, 4'hF);
    cur_req = "R9"; run_cycle(4'h0, 1, 4'h2, 32'h0300, 8'h66, LIMIT - 1, 4'h6, 4'h0, 4'hF);
    cur_req = "R10"; step(0, 4'h0); step(1, 4'h4); step(1, 4'h1); step(1, 4'h2);
    run_cycle(4'h0, 1, 4'h2, 32'h0400, 8'hC3, 0, 4'h5, 4'h0, 4'hF);
    cur_req = "R10"; step(0, 4'h0); step(1, 4'h0);
    for (int i = 0; i < 4; i++) step(1, 4'h1);
    step(1, 4'hF);
    run_cycle(4'h0, 1, 4'h0, 32'h0500, 8'h01, 0, 4'h5, 4'h0, 4'hF);
    cur_req = "R11"; sample_fall = 1'b1; fall_mode = 1'b1; idle(3);
    run_cycle(4'h0, 1, 4'h6, 32'h13572468, 8'hE7, 1, 4'h5, 4'h0, 4'hF);
    run_cycle(4'h0, 2, 4'h0, 32'h0F0F, 8'h5C, 0, 4'h5, 4'h0, 4'hF);
    cur_req = "R12"; idle(4);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule